// File: doc/BRIEF.md
# I2C Master Bus-Timing Sequencer

This block produces the clock and data line timing for an I2C controller operating as master. A controller above it issues one bus primitive at a time: a start condition, a repeated start, the transfer of one bit out or in, or a stop condition. The block then drives two open-drain enables so that the SCL high and low phases, the delay from the SCL falling edge to the SDA change, the start and stop setup and hold intervals, and the bus-free gap after a stop all follow programmable counts. All counts are in cycles of a 100 MHz reference clock.

There are two speed modes, standard (10 us nominal period) and fast (2.5 us). Each mode has its own high-phase and low-phase count. A shared SDA hold count is capped per mode. Counts that are written below their floors are raised to the floor. The high-phase counter starts only once the synchronized SCL input reads high, so a slow rise on the line lengthens the period and does not eat into the high phase. Byte framing, acknowledge handling, arbitration and clock stretching belong to the controller above and are not part of this block.

Top module: `i2c_bus_timer`

## Requirements
- R1: After synchronous reset, scl_oe and sda_oe are 0 (both lines released), busy and rd_valid are 0, standard mode is selected, and the counts are standard high 428, standard low 464, fast high 75, fast low 163, hold 0.
- R2: A configuration write (cfg_sel 0 = standard high, 1 = standard low, 2 = fast high, 3 = fast low, 4 = SDA hold, 5 = mode with bit 0 set for fast) stores the value. A high or low count below its floor (428, 464, 75, 163 respectively) is stored as the floor.
- R3: For a bit command, SCL is driven low again exactly high-count cycles after the first cycle in which the synchronized SCL input (SYNC_STAGES flops) reads high. Until then, SCL stays released.
- R4: When a command is accepted on the first cycle after the previous one completed, scl_oe stays asserted for exactly the low count.
- R5: The SDA enable takes its new value on the (hold+1)-th clock edge after acceptance. The effective hold is capped at 240 in standard mode and at 60 in fast mode.
- R6: The mode bit selects which pair of high and low counts applies. Mode and counts are captured when a command is accepted, so later writes do not affect a command in flight.
- R7: START (cmd_code 1) from idle with SCL seen high: SDA is driven low low-count cycles later and SCL is driven low high-count cycles after that. busy falls on that same edge, which is 1+low+high cycles after acceptance.
- R8: Repeated START (cmd_code 2): SDA is released during the low phase, SCL is released, and once SCL is seen high the START timing of R7 follows.
- R9: READ (cmd_code 4) samples the synchronized SDA at the midpoint of the high phase. When SCL falls, rd_valid pulses for one cycle and rd_bit holds the sample.
- R10: STOP (cmd_code 5) drives SDA low in the low phase and releases SDA high-count cycles after SCL is seen high. busy stays set for a further low-count cycles of bus-free time.
- R11: WRITE (cmd_code 3) drives SDA low for cmd_wbit 0 and releases it for 1. busy rises on acceptance. Commands presented while busy, and codes 0, 6 and 7, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz reference clock |
| rst | input | 1 | synchronous active-high reset |
| cfg_we | input | 1 | configuration write strobe |
| cfg_sel | input | 3 | configuration item select |
| cfg_wdata | input | 16 | configuration write value |
| cmd_valid | input | 1 | command present |
| cmd_code | input | 3 | command: 1 START, 2 repeated START, 3 WRITE, 4 READ, 5 STOP |
| cmd_wbit | input | 1 | bit to send for WRITE |
| scl_in | input | 1 | SCL line level (asynchronous) |
| sda_in | input | 1 | SDA line level (asynchronous) |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | command in progress |
| rd_bit | output | 1 | last sampled read bit |
| rd_valid | output | 1 | one-cycle pulse when a READ completes |

## Verification
The assertions assume that nothing else holds SCL low once the high phase has begun, and that cmd_code carries a meaningful value whenever cmd_valid is high. The bench models SCL as a line that rises and falls a fixed three cycles after the enable changes, with no other device pulling it down. SDA is driven only by the block and by a target model that holds its level steady across a whole read bit. Configuration writes made while a command is in flight change only the mode or the counts, which the block captures at acceptance.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int CNT_W = 16;

  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_START  = 3'd1,
    CMD_RSTART = 3'd2,
    CMD_WRITE  = 3'd3,
    CMD_READ   = 3'd4,
    CMD_STOP   = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_LOW, ST_RISE, ST_SETUP, ST_STAHD, ST_HIGH, ST_FREE
  } st_e;

  typedef struct packed {
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
    logic [CNT_W-1:0] hold;
  } timing_t;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sr[i] <= 1'b1;
        else     sr[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sr[i] <= 1'b1;
        else     sr[i] <= sr[i-1];
      end
    end
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/i2ct_cfg.sv
module i2ct_cfg
  import i2ct_pkg::*;
#(
  parameter int STD_HI_MIN  = 428,
  parameter int STD_LO_MIN  = 464,
  parameter int FST_HI_MIN  = 75,
  parameter int FST_LO_MIN  = 163,
  parameter int HOLD_STD_MAX = 240,
  parameter int HOLD_FST_MAX = 60,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [CNT_W-1:0] wdata,
  output timing_t          tm,
  output logic             fast
);
  localparam logic [CNT_W-1:0] SH = CNT_W'(STD_HI_MIN);
  localparam logic [CNT_W-1:0] SL = CNT_W'(STD_LO_MIN);
  localparam logic [CNT_W-1:0] FH = CNT_W'(FST_HI_MIN);
  localparam logic [CNT_W-1:0] FL = CNT_W'(FST_LO_MIN);
  localparam logic [CNT_W-1:0] HS = CNT_W'(HOLD_STD_MAX);
  localparam logic [CNT_W-1:0] HF = CNT_W'(HOLD_FST_MAX);

  logic [CNT_W-1:0] std_hi, std_lo, fst_hi, fst_lo, hold_r, hold_cap;

  function automatic logic [CNT_W-1:0] floor_at(input logic [CNT_W-1:0] v,
                                                input logic [CNT_W-1:0] m);
    return (v < m) ? m : v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      std_hi <= SH;
      std_lo <= SL;
      fst_hi <= FH;
      fst_lo <= FL;
      hold_r <= '0;
      fast   <= 1'b0;
    end else if (we) begin
      case (sel)
        SEL_W'(0): std_hi <= floor_at(wdata, SH);
        SEL_W'(1): std_lo <= floor_at(wdata, SL);
        SEL_W'(2): fst_hi <= floor_at(wdata, FH);
        SEL_W'(3): fst_lo <= floor_at(wdata, FL);
        SEL_W'(4): hold_r <= wdata;
        SEL_W'(5): fast   <= wdata[0];
        default: ;
      endcase
    end
  end

  // hold is capped per mode at use, so a mode change re-applies the cap
  always_comb begin
    hold_cap = fast ? HF : HS;
    tm.hi    = fast ? fst_hi : std_hi;
    tm.lo    = fast ? fst_lo : std_lo;
    tm.hold  = (hold_r > hold_cap) ? hold_cap : hold_r;
  end
endmodule

// File: rtl/i2ct_seq.sv
module i2ct_seq
  import i2ct_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  input  logic       cmd_wbit,
  input  timing_t    tm,
  input  logic       scl_s,
  input  logic       sda_s,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       busy,
  output logic       rd_bit,
  output logic       rd_valid
);
  st_e              st;
  cmd_e             cmd_q;
  logic             wbit_q, samp;
  timing_t          tm_q;
  logic [CNT_W-1:0] cnt;
  logic             code_ok, cnt_done, is_start;

  assign code_ok  = (cmd_code >= 3'(CMD_START)) && (cmd_code <= 3'(CMD_STOP));
  assign cnt_done = (cnt == '0);
  assign is_start = (cmd_q == CMD_START) || (cmd_q == CMD_RSTART);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cmd_q    <= CMD_NONE;
      wbit_q   <= 1'b0;
      tm_q     <= '0;
      cnt      <= '0;
      samp     <= 1'b0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      busy     <= 1'b0;
      rd_bit   <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        ST_IDLE: if (cmd_valid && code_ok) begin
          busy   <= 1'b1;
          cmd_q  <= cmd_e'(cmd_code);
          wbit_q <= cmd_wbit;
          tm_q   <= tm;
          cnt    <= tm.hold;
          st     <= (cmd_code == 3'(CMD_START)) ? ST_RISE : ST_HOLD;
        end
        ST_HOLD: if (cnt_done) begin
          case (cmd_q)
            CMD_WRITE: sda_oe <= ~wbit_q;
            CMD_STOP:  sda_oe <= 1'b1;
            default:   sda_oe <= 1'b0;
          endcase
          // low phase totals tm_q.lo cycles from the previous SCL fall
          cnt <= tm_q.lo - tm_q.hold - CNT_W'(3);
          st  <= ST_LOW;
        end else cnt <= cnt - 1'b1;
        ST_LOW: if (cnt_done) begin
          scl_oe <= 1'b0;
          st     <= ST_RISE;
        end else cnt <= cnt - 1'b1;
        ST_RISE: if (scl_s) begin
          cnt <= is_start ? tm_q.lo - 1'b1 : tm_q.hi - 1'b1;
          st  <= is_start ? ST_SETUP : ST_HIGH;
        end
        ST_SETUP: if (cnt_done) begin
          sda_oe <= 1'b1;
          cnt    <= tm_q.hi - 1'b1;
          st     <= ST_STAHD;
        end else cnt <= cnt - 1'b1;
        ST_STAHD: if (cnt_done) begin
          scl_oe <= 1'b1;
          busy   <= 1'b0;
          st     <= ST_IDLE;
        end else cnt <= cnt - 1'b1;
        ST_HIGH: begin
          if (cmd_q == CMD_READ && cnt == (tm_q.hi >> 1)) samp <= sda_s;
          if (cnt_done) begin
            if (cmd_q == CMD_STOP) begin
              sda_oe <= 1'b0;
              cnt    <= tm_q.lo - 1'b1;
              st     <= ST_FREE;
            end else begin
              scl_oe <= 1'b1;
              busy   <= 1'b0;
              st     <= ST_IDLE;
              if (cmd_q == CMD_READ) begin
                rd_bit   <= samp;
                rd_valid <= 1'b1;
              end
            end
          end else cnt <= cnt - 1'b1;
        end
        ST_FREE: if (cnt_done) begin
          busy <= 1'b0;
          st   <= ST_IDLE;
        end else cnt <= cnt - 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_bus_timer.sv
module i2c_bus_timer
  import i2ct_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int STD_HI_MIN   = 428,
  parameter int STD_LO_MIN   = 464,
  parameter int FST_HI_MIN   = 75,
  parameter int FST_LO_MIN   = 163,
  parameter int HOLD_STD_MAX = 240,
  parameter int HOLD_FST_MAX = 60,
  parameter int SEL_W        = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_code,
  input  logic             cmd_wbit,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             busy,
  output logic             rd_bit,
  output logic             rd_valid
);
  timing_t tm;
  logic    fast_sel, scl_s, sda_s;

  i2ct_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst(rst), .d(scl_in), .q(scl_s));
  i2ct_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst(rst), .d(sda_in), .q(sda_s));

  i2ct_cfg #(
    .STD_HI_MIN(STD_HI_MIN), .STD_LO_MIN(STD_LO_MIN),
    .FST_HI_MIN(FST_HI_MIN), .FST_LO_MIN(FST_LO_MIN),
    .HOLD_STD_MAX(HOLD_STD_MAX), .HOLD_FST_MAX(HOLD_FST_MAX),
    .SEL_W(SEL_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .tm(tm), .fast(fast_sel));

  i2ct_seq u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_wbit(cmd_wbit), .tm(tm), .scl_s(scl_s), .sda_s(sda_s),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .rd_bit(rd_bit),
    .rd_valid(rd_valid));
endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk
  import i2ct_pkg::*;
#(
  parameter int STD_HI_MIN   = 428,
  parameter int STD_LO_MIN   = 464,
  parameter int FST_HI_MIN   = 75,
  parameter int FST_LO_MIN   = 163,
  parameter int HOLD_STD_MAX = 240,
  parameter int HOLD_FST_MAX = 60
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [2:0]       cmd_code,
  input logic             busy,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             scl_s,
  input logic             rd_valid,
  input logic             fast_sel,
  input logic [CNT_W-1:0] tm_hi,
  input logic [CNT_W-1:0] tm_lo,
  input logic [CNT_W-1:0] tm_hold
);
  logic accept;
  assign accept = cmd_valid && !busy && (cmd_code >= 3'd1) && (cmd_code <= 3'd5);

  p_accept_busy_r11: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (!busy && !accept) |=> ($stable(scl_oe) && $stable(sda_oe)));

  p_wait_line_high_r3: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && !scl_s) |=> !scl_oe);

  p_count_floor_r2: assert property (@(posedge clk) disable iff (rst)
    fast_sel ? (tm_hi >= CNT_W'(FST_HI_MIN) && tm_lo >= CNT_W'(FST_LO_MIN))
             : (tm_hi >= CNT_W'(STD_HI_MIN) && tm_lo >= CNT_W'(STD_LO_MIN)));

  p_hold_cap_r5: assert property (@(posedge clk) disable iff (rst)
    tm_hold <= (fast_sel ? CNT_W'(HOLD_FST_MAX) : CNT_W'(HOLD_STD_MAX)));

  p_rd_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  p_rd_done_r9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (!busy && scl_oe));

  p_start_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_oe) && !scl_oe) |=> !scl_oe);
endmodule

bind i2c_bus_timer i2ct_chk #(
  .STD_HI_MIN(STD_HI_MIN), .STD_LO_MIN(STD_LO_MIN),
  .FST_HI_MIN(FST_HI_MIN), .FST_LO_MIN(FST_LO_MIN),
  .HOLD_STD_MAX(HOLD_STD_MAX), .HOLD_FST_MAX(HOLD_FST_MAX)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .busy(busy), .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_s(scl_s),
  .rd_valid(rd_valid), .fast_sel(fast_sel),
  .tm_hi(tm.hi), .tm_lo(tm.lo), .tm_hold(tm.hold));

// File: tb/sim_i2c_bus_timer.sv
module sim_i2c_bus_timer;
  localparam int SS = 2;     // synchronizer depth in the design
  localparam int RDLY = 3;   // modelled line rise/fall delay in cycles
  localparam int SH = 428, SL = 464, FH = 75, FL = 163;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_code = '0;
  logic cmd_wbit = 1'b0;
  logic scl_in, sda_in, scl_oe, sda_oe, busy, rd_bit, rd_valid;
  logic slave_low = 1'b0;
  logic [RDLY-1:0] scl_chain = '1;

  always @(posedge clk) scl_chain <= {scl_chain[RDLY-2:0], ~scl_oe};
  assign scl_in = scl_chain[RDLY-1];
  assign sda_in = ~sda_oe & ~slave_low;

  i2c_bus_timer #(.SYNC_STAGES(SS)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_wbit(cmd_wbit), .scl_in(scl_in), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .rd_bit(rd_bit),
    .rd_valid(rd_valid));

  int errors = 0, checks = 0;
  bit done = 1'b0;
  int low_run = 0, rel_run = 0, last_low = 0, last_rel = 0, rdv_cnt = 0;

  always @(negedge clk) begin
    if (scl_oe) begin
      if (rel_run != 0) last_rel = rel_run;
      rel_run = 0;
      low_run++;
    end else begin
      if (low_run != 0) last_low = low_run;
      low_run = 0;
      rel_run++;
    end
  end
  always @(posedge clk) if (!rst && rd_valid) rdv_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [15:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // issue at the current negedge; returns busy length and cycles SDA held
  task automatic do_cmd(input logic [2:0] code, input logic wbit,
                        output int dur, output int hcnt);
    logic s0;
    bit same;
    s0 = sda_oe; same = 1'b1; dur = 0; hcnt = 0;
    cmd_valid = 1'b1; cmd_code = code; cmd_wbit = wbit;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) begin
      dur++;
      if (same && sda_oe == s0) hcnt++; else same = 1'b0;
      @(negedge clk);
    end
  endtask

  function automatic int exp_dur(input logic [2:0] code, input int lo, input int hi);
    case (code)
      3'd1:       return lo + hi + 1;
      3'd2, 3'd5: return 2 * lo + hi + RDLY + SS;
      default:    return lo + hi + RDLY + SS;
    endcase
  endfunction

  typedef struct packed {
    logic [2:0] code;
    logic wbit;
    logic slv;
    logic exp_rd;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{3'd1, 1'b0, 1'b0, 1'b0},
    '{3'd3, 1'b1, 1'b0, 1'b0},
    '{3'd3, 1'b0, 1'b0, 1'b0},
    '{3'd4, 1'b0, 1'b1, 1'b0},
    '{3'd4, 1'b0, 1'b0, 1'b1},
    '{3'd2, 1'b0, 1'b0, 1'b0},
    '{3'd3, 1'b0, 1'b0, 1'b0},
    '{3'd4, 1'b0, 1'b1, 1'b0},
    '{3'd5, 1'b0, 1'b0, 1'b0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int d, h;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(scl_oe == 1'b0, "R1 scl_oe", scl_oe, 0);
    chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);

    // table of commands in standard mode with reset counts
    for (int i = 0; i < 9; i++) begin
      slave_low = VEC[i].slv;
      do_cmd(VEC[i].code, VEC[i].wbit, d, h);
      chk(d == exp_dur(VEC[i].code, SL, SH), "R7 R8 R10 R11 busy length", d,
          exp_dur(VEC[i].code, SL, SH));
      if (VEC[i].code == 3'd4)
        chk(rd_bit == VEC[i].exp_rd, "R9 rd_bit", rd_bit, VEC[i].exp_rd);
      if (VEC[i].code == 3'd1) begin
        chk(sda_oe && scl_oe, "R7 lines after start", {sda_oe, scl_oe}, 3);
      end
    end
    slave_low = 1'b0;
    @(negedge clk);
    chk(rdv_cnt == 3, "R9 rd_valid pulses", rdv_cnt, 3);
    chk(!sda_oe && !scl_oe, "R10 lines after stop", {sda_oe, scl_oe}, 0);

    // back-to-back phase widths
    do_cmd(3'd1, 1'b0, d, h);
    do_cmd(3'd3, 1'b1, d, h);
    do_cmd(3'd3, 1'b0, d, h);
    @(negedge clk);
    chk(last_low == SL, "R4 low width", last_low, SL);
    chk(last_rel == SH + RDLY + SS + 1, "R3 released width", last_rel, SH + RDLY + SS + 1);

    // hold delays (sda_oe currently 1, write 1 releases it)
    cfg_write(3'd4, 16'd100);
    do_cmd(3'd3, 1'b1, d, h);
    chk(h == 101, "R5 hold 100", h, 101);
    do_cmd(3'd3, 1'b0, d, h);
    cfg_write(3'd4, 16'd500);
    do_cmd(3'd3, 1'b1, d, h);
    chk(h == 241, "R5 hold cap standard", h, 241);
    do_cmd(3'd3, 1'b0, d, h);
    cfg_write(3'd4, 16'd0);
    do_cmd(3'd3, 1'b1, d, h);
    chk(h == 1, "R5 hold 0", h, 1);

    // clamp of counts
    cfg_write(3'd0, 16'd10);
    do_cmd(3'd3, 1'b0, d, h);
    chk(d == SL + SH + RDLY + SS, "R2 std high floor", d, SL + SH + RDLY + SS);
    cfg_write(3'd0, 16'd500);
    do_cmd(3'd3, 1'b0, d, h);
    chk(d == SL + 500 + RDLY + SS, "R2 std high written", d, SL + 500 + RDLY + SS);

    // fast mode
    cfg_write(3'd3, 16'd5);
    cfg_write(3'd5, 16'd1);
    cfg_write(3'd4, 16'd100);
    do_cmd(3'd3, 1'b1, d, h);
    chk(d == FL + FH + RDLY + SS, "R6 fast length", d, FL + FH + RDLY + SS);
    chk(h == 61, "R5 hold cap fast", h, 61);
    fork
      do_cmd(3'd3, 1'b0, d, h);
      begin repeat (20) @(negedge clk); cfg_write(3'd5, 16'd0); end
    join
    chk(d == FL + FH + RDLY + SS, "R6 mode captured", d, FL + FH + RDLY + SS);
    do_cmd(3'd3, 1'b0, d, h);
    chk(d == SL + 500 + RDLY + SS, "R6 back to standard", d, SL + 500 + RDLY + SS);

    // command while busy ignored
    fork
      do_cmd(3'd3, 1'b0, d, h);
      begin
        repeat (3) @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 3'd5;
        repeat (5) @(negedge clk);
        cmd_valid = 1'b0;
      end
    join
    chk(d == SL + 500 + RDLY + SS, "R11 busy ignores", d, SL + 500 + RDLY + SS);
    chk(scl_oe && sda_oe, "R11 no stop taken", {scl_oe, sda_oe}, 3);

    // invalid codes ignored
    cmd_valid = 1'b1; cmd_code = 3'd0;
    @(negedge clk);
    cmd_code = 3'd7;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    chk(!busy && scl_oe && sda_oe, "R11 invalid code", {busy, scl_oe, sda_oe}, 3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule